// File: doc/BRIEF.md
# Signed Multiply-Accumulator with Upper-Word Preload

The block multiplies two signed 18-bit operands every cycle and adds the product to, or subtracts it from, a 52-bit two's complement running sum. A load control restarts the sum: on the cycle it takes effect, the running sum is replaced by a load value built from the current product and a 36-bit upper-preload word. With the preload word at zero this is a clear-and-restart that loses no cycle. With a non-zero word it seeds bits 51:16 of the sum. A multiply-by-one on the same cycle supplies the low bits.

Operands, the add/subtract select and the preload word are registered once at the input. The accumulator register updates on the following edge. The load control goes through a parameter-chosen number of register stages (0, 1 or 2). With the default of 1 it lines up with the operands it travels with. A flag reports signed overflow or underflow of the most recent add or subtract.

Top module: `mac_preload`

## Requirements
- R1: A synchronous active-high reset clears the accumulated result, the overflow flag and every pipeline register. The result reads 0 on the first cycle after reset.
- R2: Operands presented before clock edge k show up in the result after edge k+1. When load is inactive, the result becomes the previous result plus or minus the 36-bit signed product of the two operands, sign-extended to 52 bits.
- R3: The add/subtract select travels with its operands and may change on any cycle. 0 adds the product and 1 subtracts it.
- R4: With LOAD_STAGES=1, a load presented together with operands makes the sum restart from that product. With the preload word at 0 the result equals the sign-extended product, and accumulation continues on the next cycle with no idle cycle in between.
- R5: A load with a non-zero preload word P places P in the upper part of the sum. With the default overlap setting the load value is {P[35:2], 18'b0} plus the sign-extended product. Operands of 1 and x (0 ≤ x < 65536) therefore give a full 52-bit value of {P[35:2], 2'b00, x[15:0]}.
- R6: On bits 17:16, parameter PROD_WINS_OVERLAP picks the source for a load. When it is 1 (the default), the product supplies those bits and P[1:0] is ignored. When it is 0, P[1:0] is used and only product bits 15:0 are kept.
- R7: The overflow flag is 1 after an edge exactly when that edge's add or subtract leaves the signed 52-bit range. It is 0 after a load edge and is recomputed on every edge, so it is not sticky.
- R8: LOAD_STAGES sets the register stages on the load path. An instance with 0 stages, whose load is presented one cycle after its operands, produces the same results as a 1-stage instance whose load is presented with its operands.
- R9: Holding one operand at 1 turns the block into a pure accumulator of the other operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 18 | Signed operand A |
| b_i | input | 18 | Signed operand B |
| sub_i | input | 1 | 1 subtracts the product, 0 adds it |
| load_i | input | 1 | Restart or preload control (goes through LOAD_STAGES registers) |
| pre_i | input | 36 | Upper-preload word for bits 51:16 |
| acc_o | output | 52 | Accumulated signed result |
| ovf_o | output | 1 | Overflow/underflow of the latest add or subtract |

## Verification
Operands, the select and the preload word driven before edge k are due on the result and the flag after edge k+1. The load is due at the same edge when it goes through one stage, and one cycle later when it goes through none. The bench drives on the falling edge and holds each stimulus in a pending slot for one cycle. Just after the next rising edge it advances its own model with that pending stimulus, then compares the result and the flag. The 0-stage instance gets a load copied from the previous step, so its result is compared against the main instance on the same cycle.

// File: rtl/mac_preload.sv
module mac_preload #(
  parameter int OP_W              = 18,
  parameter int ACC_W             = 52,
  parameter int PRE_W             = 36,
  parameter int LOAD_STAGES       = 1,
  parameter bit PROD_WINS_OVERLAP = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic             sub_i,
  input  logic             load_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf_o
);
  localparam int PROD_W  = 2 * OP_W;
  localparam int PRE_LSB = ACC_W - PRE_W;
  localparam int OVL_W   = OP_W - PRE_LSB;

  logic signed [OP_W-1:0]   a_q, b_q;
  logic                     sub_q;
  logic [PRE_W-1:0]         pre_q;
  logic                     ld_now;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         prod_x, load_val, sum, acc_q;
  logic                     ovf_q, ovf_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      sub_q <= 1'b0;
      pre_q <= '0;
    end else begin
      a_q   <= a_i;
      b_q   <= b_i;
      sub_q <= sub_i;
      pre_q <= pre_i;
    end
  end

  generate
    if (LOAD_STAGES == 0) begin : g_ld0
      assign ld_now = load_i;
    end else if (LOAD_STAGES == 1) begin : g_ld1
      logic ld_q;
      always_ff @(posedge clk) ld_q <= rst ? 1'b0 : load_i;
      assign ld_now = ld_q;
    end else begin : g_ld2
      logic [1:0] ld_q;
      always_ff @(posedge clk) ld_q <= rst ? 2'b00 : {ld_q[0], load_i};
      assign ld_now = ld_q[1];
    end
  endgenerate

  assign prod   = a_q * b_q;
  assign prod_x = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  generate
    if (PROD_WINS_OVERLAP) begin : g_ovl_prod
      assign load_val = {pre_q[PRE_W-1:OVL_W], {OP_W{1'b0}}} + prod_x;
    end else begin : g_ovl_pre
      assign load_val = {pre_q, prod[PRE_LSB-1:0]};
    end
  endgenerate

  assign sum = sub_q ? acc_q - prod_x : acc_q + prod_x;

  always_comb begin
    if (sub_q)
      ovf_n = (acc_q[ACC_W-1] != prod_x[ACC_W-1]) && (sum[ACC_W-1] != acc_q[ACC_W-1]);
    else
      ovf_n = (acc_q[ACC_W-1] == prod_x[ACC_W-1]) && (sum[ACC_W-1] != acc_q[ACC_W-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (ld_now) begin
      acc_q <= load_val;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= sum;
      ovf_q <= ovf_n;
    end
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;
endmodule

module mac_preload_chk #(
  parameter int ACC_W = 52,
  parameter int OP_W  = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             ld_now,
  input logic [OP_W-1:0]  a_q,
  input logic [ACC_W-1:0] acc_o,
  input logic             ovf_o
);
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> (acc_o == '0 && !ovf_o));
  p_load_no_flag_r7: assert property (@(posedge clk) disable iff (rst) ld_now |=> !ovf_o);
  p_flag_flips_sign_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !$past(rst)) |-> (acc_o[ACC_W-1] != $past(acc_o[ACC_W-1])));
  p_zero_product_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (!ld_now && a_q == '0) |=> $stable(acc_o));
  p_zero_product_no_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (!ld_now && a_q == '0) |=> !ovf_o);
endmodule

bind mac_preload mac_preload_chk #(.ACC_W(ACC_W), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .ld_now(ld_now), .a_q(a_q), .acc_o(acc_o), .ovf_o(ovf_o)
);

// File: tb/mac_preload_tb.sv
module mac_preload_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] a_i = '0, b_i = '0;
  logic        sub_i = 1'b0, load_i = 1'b0, load0_i = 1'b0;
  logic [35:0] pre_i = '0;
  logic [51:0] acc_o, acc0_o;
  logic        ovf_o, ovf0_o;

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [17:0] p_a, p_b;
  logic        p_sub, p_ld;
  logic [35:0] p_pre;
  logic [51:0] exp_acc;
  logic        exp_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_preload u_dut (
    .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
    .load_i(load_i), .pre_i(pre_i), .acc_o(acc_o), .ovf_o(ovf_o));

  mac_preload #(.LOAD_STAGES(0)) u_dut_nopipe (
    .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
    .load_i(load0_i), .pre_i(pre_i), .acc_o(acc0_o), .ovf_o(ovf0_o));

  function automatic logic [51:0] sext_prod(input logic [17:0] a, input logic [17:0] b);
    longint pa, pb;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    return 52'(pa * pb);
  endfunction

  task automatic model();
    logic signed [52:0] wide;
    logic [51:0] p;
    p = sext_prod(p_a, p_b);
    if (p_ld) begin
      exp_acc = {p_pre[35:2], 18'b0} + p;
      exp_ovf = 1'b0;
    end else begin
      if (p_sub) wide = $signed({exp_acc[51], exp_acc}) - $signed({p[51], p});
      else       wide = $signed({exp_acc[51], exp_acc}) + $signed({p[51], p});
      exp_ovf = (wide[52] != wide[51]);
      exp_acc = wide[51:0];
    end
  endtask

  task automatic check(input string req, input logic [51:0] act, input logic [51:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(input logic [17:0] a, input logic [17:0] b, input logic sub,
                      input logic ld, input logic [35:0] pre, input string req);
    @(negedge clk);
    a_i = a; b_i = b; sub_i = sub; load_i = ld; pre_i = pre;
    load0_i = p_ld;
    @(posedge clk);
    #1;
    model();
    check(req, acc_o, exp_acc);
    check("R7 overflow flag", 52'(ovf_o), 52'(exp_ovf));
    check("R8 zero-stage load path", acc0_o, acc_o);
    p_a = a; p_b = b; p_sub = sub; p_ld = ld; p_pre = pre;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; a_i = '0; b_i = '0; sub_i = 0; load_i = 0; load0_i = 0; pre_i = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    p_a = '0; p_b = '0; p_sub = 0; p_ld = 0; p_pre = '0;
    exp_acc = '0; exp_ovf = 0;
    #1;
    check("R1 reset result", acc_o, '0);
    check("R1 reset flag", 52'(ovf_o), 52'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R2 R3: plain accumulate, add then subtract
    step(18'd3, 18'd5, 0, 0, '0, "R2 accumulate add");
    step(-18'sd7, 18'd9, 0, 0, '0, "R2 accumulate negative product");
    step(18'd100, 18'd100, 1, 0, '0, "R3 subtract");
    step(18'd0, 18'd0, 0, 0, '0, "R2 pipeline drain");
    // R4: back-to-back restart with no lost cycle
    step(18'd11, 18'd12, 0, 1, '0, "R4 restart from product");
    step(18'd2, 18'd2, 0, 0, '0, "R4 restart result");
    step(-18'sd4, 18'd6, 0, 1, '0, "R4 second restart");
    step(18'd1, 18'd1, 1, 0, '0, "R4 continue after restart");
    // R5 R9: full preload via multiply-by-one then pure accumulation
    step(18'd1, 18'h0BEEF, 0, 1, 36'hABCDE1234, "R5 full preload");
    step(18'd1, 18'd25, 0, 0, '0, "R5 preload value");
    step(18'd1, 18'd25, 1, 0, '0, "R9 pure accumulate");
    // R6: preload bits 1:0 ignored, product supplies bits 17:16
    step(18'd1, 18'h30000, 0, 1, 36'h000000003, "R9 pure accumulate step");
    step(18'd0, 18'd0, 0, 0, '0, "R6 overlap from product");
    // R7: drive positive overflow then flag clears
    step(18'd1, 18'd1, 0, 1, 36'h7FFFFFFFF, "R6 overlap result");
    step(18'h20000, 18'h20000, 0, 0, '0, "R5 preload near max");
    step(18'h20000, 18'h20000, 0, 0, '0, "R7 overflow set");
    step(18'd0, 18'd0, 0, 0, '0, "R7 second add");
    step(18'd0, 18'd0, 0, 0, '0, "R7 flag not sticky");
    // R7: underflow via subtract
    step(18'd1, 18'd0, 0, 1, 36'h800000000, "R7 load neg max");
    step(18'h1FFFF, 18'h1FFFF, 1, 0, '0, "R7 load result");
    step(18'd0, 18'd0, 0, 0, '0, "R7 underflow set");
    step(18'd0, 18'd0, 0, 0, '0, "R7 underflow cleared");
    // R1: reset mid-stream
    step(18'd77, 18'd77, 0, 0, '0, "R2 before reset");
    do_reset();
    // R2 R3 R4 R8: constrained random mix
    for (int i = 0; i < 400; i++) begin
      step(18'($urandom), 18'($urandom), 1'($urandom), ($urandom % 8) == 0,
           (($urandom % 2) == 0) ? 36'd0 : {4'($urandom), 32'($urandom)}, "R2 random mix");
    end
    step(18'd0, 18'd0, 0, 0, '0, "R2 final drain");
    step(18'd0, 18'd0, 0, 0, '0, "R2 final drain");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule